// File: doc/BRIEF.md
# Wiper Setting Store and Recall Controller

This block owns the 6-bit position code of a 64-step digital potentiometer together with a small bank of nonvolatile words in which that code can be kept. It is modelled as a register array whose writes take a programmable number of clock cycles. When the part powers up, the wiper starts at midscale (0x20). After a timed recall the wiper takes the saved setting. Nonvolatile writes stay locked out until a rewrite window has passed.

A serial front end decodes bus transfers and hands each instruction to the block as a single-cycle strobe. The strobe carries a 3-bit opcode, a 5-bit location, a read flag and a data byte. There is no back-pressure on this strobe. A strobe that arrives while `busy` is high is discarded, and `cmd_err` pulses for one cycle. Read results leave on a valid/ready channel. `rd_valid` stays high and `rd_data` stays frozen until the consumer raises `rd_ready`. A new read is refused while a result is still waiting, so the result register never overflows.

There are two resets. `por_n` models the very first supply-on of a blank part, so it also blanks the nonvolatile bank. `rst_n` models a later power cycle: it restarts the preset, recall and lockout sequence and keeps the stored words. All durations are parameters counted in clock cycles.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While either reset is low, `wiper` is 0x20, `busy` is 1, and `rd_valid`, `cmd_err` and `nv_read_on` are 0. Write protection is off after reset.
- R2: After reset release, `wiper` holds 0x20 for RESTORE_CYC-1 cycles and then takes nonvolatile word 0. A bank blanked by `por_n` holds 0x20 in every word.
- R3: `busy` stays high for exactly REWRITE_CYC cycles after reset release. A strobe seen while `busy` is high has no effect, and `cmd_err` is 1 in the following cycle.
- R4: Opcode 000 with read flag 0 loads `cmd_data[5:0]` into `wiper` on the next cycle; bits 7:6 are ignored. With read flag 1 it returns {2'b00, wiper}.
- R5: Opcode 001 with read flag 0 and a location below NV_WORDS writes `cmd_data[5:0]` to that word, holding `busy` for STORE_CYC cycles. Opcode 110 saves `wiper` into word 0 with the same timing. Opcode 001 with read flag 1 returns {2'b00, word}.
- R6: Opcode 101 holds `busy` for RESTORE_CYC cycles and then loads word 0 into `wiper`. `nv_read_on` rises the cycle after acceptance and stays high until opcode 100 clears it.
- R7: Opcode 010 sets write protection to `cmd_data[0]` (1 = on, 0 = off). While it is on, opcode 001 writes and opcode 110 are refused with `cmd_err`, cause no `busy`, and leave the words unchanged. Opcode 000 writes still work.
- R8: Location 11110 reads as the tolerance sign/integer byte (bit 7 = 1 means negative, bits 6:0 = whole percent). Location 11111 reads as the tolerance fraction byte (LSB = 2^-8 percent). Writes to these locations, or to any location at or above NV_WORDS, are refused with `cmd_err`. Other unmapped locations read 0.
- R9: `rd_valid` rises the cycle after an accepted read. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds steady. `rd_valid` falls the cycle after the handshake. A read strobed while a result waits is refused with `cmd_err`.
- R10: Opcodes 011 and 111 are refused with `cmd_err` and change nothing.
- R11: A cycle of `rst_n` alone keeps the nonvolatile words. After release, the wiper comes back from midscale to the saved word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-cycle reset; stored words survive |
| por_n | input | 1 | Active-low first-power reset; also blanks the stored words |
| cmd_valid | input | 1 | Single-cycle instruction strobe |
| cmd_op | input | 3 | Opcode |
| cmd_rd | input | 1 | 1 = read access for opcodes 000 and 001 |
| cmd_addr | input | 5 | Nonvolatile location |
| cmd_data | input | 8 | Data byte |
| rd_valid | output | 1 | Read result available |
| rd_ready | input | 1 | Consumer takes the read result |
| rd_data | output | 8 | Read result byte |
| wiper | output | 6 | Current wiper code |
| busy | output | 1 | Lockout, store or recall in progress |
| cmd_err | output | 1 | One-cycle pulse for a dropped or refused strobe |
| nv_read_on | output | 1 | High-power recall state, cleared by NOP |

## Verification
The bench builds the block with RESTORE_CYC=5, STORE_CYC=9, REWRITE_CYC=12 and four stored words. With these values the whole boot sequence, every store and every recall finish within a few dozen cycles. That makes it practical to check the exact cycle at which `busy` falls and the wiper changes. It also lets the bench sweep all 64 wiper codes, all four words, both tolerance locations, every opcode, and both kinds of power cycle.

// File: rtl/wnv_pkg.sv
`timescale 1ns/1ps
package wnv_pkg;

  typedef enum logic [2:0] {
    OP_WIPER  = 3'b000,
    OP_NVM    = 3'b001,
    OP_PROT   = 3'b010,
    OP_NOP    = 3'b100,
    OP_RECALL = 3'b101,
    OP_SAVE   = 3'b110
  } op_e;

  typedef enum logic {
    JOB_RECALL = 1'b0,
    JOB_SAVE   = 1'b1
  } job_e;

endpackage

// File: rtl/wnv_timer.sv
`timescale 1ns/1ps
module wnv_timer #(
  parameter int CNT_W   = 24,
  parameter int RST_LEN = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             active,
  output logic             fire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= CNT_W'(RST_LEN);
    else if (start)      cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
  assign fire   = (cnt == CNT_W'(1));

  // The last counted cycle ends the window (R3)
  p_window_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !start |=> !active);

endmodule

// File: rtl/wnv_store.sv
`timescale 1ns/1ps
module wnv_store #(
  parameter int         W      = 6,
  parameter int         WORDS  = 4,
  parameter int         ADDR_W = 5,
  parameter logic [7:0] TOL_SGN = 8'h87,
  parameter logic [7:0] TOL_FRC = 8'hA0
) (
  input  logic                                     clk,
  input  logic                                     por_n,
  input  logic                                     wr_en,
  input  logic [((WORDS > 1) ? $clog2(WORDS) : 1)-1:0] wr_idx,
  input  logic [W-1:0]                             wr_data,
  input  logic [ADDR_W-1:0]                        rd_addr,
  output logic [7:0]                               rd_byte,
  output logic [W-1:0]                             home
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [W-1:0]      BLANK  = W'(1) << (W - 1);
  localparam logic [ADDR_W-1:0] A_FRC  = '1;
  localparam logic [ADDR_W-1:0] A_SGN  = A_FRC - 1'b1;
  localparam logic [ADDR_W:0]   LIMIT  = (ADDR_W + 1)'(WORDS);

  logic [WORDS-1:0][W-1:0] words;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!por_n)                                words[g] <= BLANK;
      else if (wr_en && wr_idx == IDX_W'(g))     words[g] <= wr_data;
    end
  end

  always_comb begin
    rd_byte = '0;
    if (rd_addr == A_SGN)                       rd_byte = TOL_SGN;
    else if (rd_addr == A_FRC)                  rd_byte = TOL_FRC;
    else if ({1'b0, rd_addr} < LIMIT)           rd_byte[W-1:0] = words[rd_addr[IDX_W-1:0]];
  end

  assign home = words[0];

  // Nonvolatile contents move only on a commit (R7)
  p_words_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(words));

endmodule

// File: rtl/wiper_nv_ctrl.sv
`timescale 1ns/1ps
module wiper_nv_ctrl #(
  parameter int         W           = 6,
  parameter int         NV_WORDS    = 4,
  parameter int         ADDR_W      = 5,
  parameter int         CNT_W       = 24,
  parameter int         RESTORE_CYC = 75000,
  parameter int         STORE_CYC   = 6500000,
  parameter int         REWRITE_CYC = 135000,
  parameter logic [7:0] TOL_SGN     = 8'h87,
  parameter logic [7:0] TOL_FRC     = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic [W-1:0]      wiper,
  output logic              busy,
  output logic              cmd_err,
  output logic              nv_read_on
);
  import wnv_pkg::*;

  localparam int              IDX_W  = (NV_WORDS > 1) ? $clog2(NV_WORDS) : 1;
  localparam logic [W-1:0]    MID    = W'(1) << (W - 1);
  localparam logic [ADDR_W:0] NV_LIM = (ADDR_W + 1)'(NV_WORDS);

  logic live_n;
  assign live_n = rst_n & por_n;

  // ---- timers ----
  logic             lock_act, lock_fire;
  logic             op_act, op_fire;
  logic             job_go;
  logic [CNT_W-1:0] job_len;

  wnv_timer #(.CNT_W(CNT_W), .RST_LEN(REWRITE_CYC)) u_lock (
    .clk(clk), .rst_n(live_n), .start(1'b0), .len('0),
    .active(lock_act), .fire(lock_fire)
  );

  wnv_timer #(.CNT_W(CNT_W), .RST_LEN(RESTORE_CYC)) u_job (
    .clk(clk), .rst_n(live_n), .start(job_go), .len(job_len),
    .active(op_act), .fire(op_fire)
  );

  assign busy = lock_act | op_act;

  // ---- state ----
  logic [W-1:0]     wiper_q;
  logic             wp_q;
  logic             readmode_q;
  logic             rd_valid_q;
  logic [7:0]       rd_data_q;
  logic             err_q;
  job_e             job_q;
  logic [IDX_W-1:0] job_idx;
  logic [W-1:0]     job_data;

  // ---- nonvolatile bank ----
  logic       commit;
  logic [7:0] st_byte;
  logic [W-1:0] home;

  assign commit = op_fire && (job_q == JOB_SAVE);

  wnv_store #(.W(W), .WORDS(NV_WORDS), .ADDR_W(ADDR_W),
              .TOL_SGN(TOL_SGN), .TOL_FRC(TOL_FRC)) u_store (
    .clk(clk), .por_n(por_n), .wr_en(commit), .wr_idx(job_idx),
    .wr_data(job_data), .rd_addr(cmd_addr), .rd_byte(st_byte), .home(home)
  );

  // ---- instruction decode ----
  logic take, nv_hit;
  logic acc_wwr, acc_prot, acc_nop, acc_recall, acc_nvwr, acc_save, rd_ok, refuse;

  assign nv_hit = ({1'b0, cmd_addr} < NV_LIM);

  always_comb begin
    take       = cmd_valid && !busy;
    acc_wwr    = 1'b0;
    acc_prot   = 1'b0;
    acc_nop    = 1'b0;
    acc_recall = 1'b0;
    acc_nvwr   = 1'b0;
    acc_save   = 1'b0;
    rd_ok      = 1'b0;
    refuse     = 1'b0;
    if (take) begin
      case (cmd_op)
        OP_WIPER: begin
          if (!cmd_rd)         acc_wwr = 1'b1;
          else if (rd_valid_q) refuse  = 1'b1;
          else                 rd_ok   = 1'b1;
        end
        OP_NVM: begin
          if (cmd_rd) begin
            if (rd_valid_q) refuse = 1'b1;
            else            rd_ok  = 1'b1;
          end else if (nv_hit && !wp_q) acc_nvwr = 1'b1;
          else                          refuse   = 1'b1;
        end
        OP_PROT:   acc_prot   = 1'b1;
        OP_NOP:    acc_nop    = 1'b1;
        OP_RECALL: acc_recall = 1'b1;
        OP_SAVE: begin
          if (wp_q) refuse   = 1'b1;
          else      acc_save = 1'b1;
        end
        default:   refuse     = 1'b1;
      endcase
    end
  end

  assign job_go  = acc_nvwr | acc_save | acc_recall;
  assign job_len = acc_recall ? CNT_W'(RESTORE_CYC) : CNT_W'(STORE_CYC);

  // ---- registers ----
  always_ff @(posedge clk) begin
    if (!live_n) begin
      wiper_q    <= MID;
      wp_q       <= 1'b0;
      readmode_q <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      err_q      <= 1'b0;
      job_q      <= JOB_RECALL;
      job_idx    <= '0;
      job_data   <= '0;
    end else begin
      err_q <= (cmd_valid && busy) || refuse;

      if (acc_wwr)                              wiper_q <= cmd_data[W-1:0];
      else if (op_fire && job_q == JOB_RECALL)  wiper_q <= home;

      if (acc_prot) wp_q <= cmd_data[0];

      if (acc_recall)   readmode_q <= 1'b1;
      else if (acc_nop) readmode_q <= 1'b0;

      if (job_go) begin
        job_q    <= acc_recall ? JOB_RECALL : JOB_SAVE;
        job_idx  <= acc_nvwr ? cmd_addr[IDX_W-1:0] : '0;
        job_data <= acc_nvwr ? cmd_data[W-1:0] : wiper_q;
      end

      if (rd_ok) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= (cmd_op == OP_WIPER) ? 8'(wiper_q) : st_byte;
      end else if (rd_valid_q && rd_ready) begin
        rd_valid_q <= 1'b0;
      end
    end
  end

  assign wiper      = wiper_q;
  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign cmd_err    = err_q;
  assign nv_read_on = readmode_q;

  // ---- assertions ----
  // R2: midscale is held while the boot recall is still running
  p_boot_preset_r2: assert property (@(posedge clk) disable iff (!live_n)
    lock_act && op_act |-> wiper == MID);

  // R3: a strobe during busy is flagged and leaves protection and mode alone
  p_busy_drop_r3: assert property (@(posedge clk) disable iff (!live_n)
    cmd_valid && busy |=> cmd_err && $stable(wp_q) && $stable(nv_read_on));

  // R6: high-power recall state is only left through NOP
  p_readmode_hold_r6: assert property (@(posedge clk) disable iff (!live_n)
    nv_read_on && !acc_nop |=> nv_read_on);

  // R7: no nonvolatile commit ever completes with protection on
  p_commit_unprot_r7: assert property (@(posedge clk) disable iff (!live_n)
    commit |-> !wp_q);

  // R9: a waiting result is frozen until taken
  p_resp_hold_r9: assert property (@(posedge clk) disable iff (!live_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

endmodule

// File: tb/wiper_nv_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_nv_ctrl_bench;

  localparam int RC = 5;
  localparam int SC = 9;
  localparam int LC = 12;
  localparam logic [7:0] TSG = 8'h87;
  localparam logic [7:0] TFR = 8'hA0;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rd = 1'b0, rd_ready = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [4:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic rd_valid, busy, cmd_err, nv_read_on;
  logic [7:0] rd_data;
  logic [5:0] wiper;

  int n_chk = 0, n_bad = 0;
  logic [5:0] exp_nv [4];

  always #2 clk = ~clk;

  wiper_nv_ctrl #(.W(6), .NV_WORDS(4), .ADDR_W(5), .CNT_W(16),
    .RESTORE_CYC(RC), .STORE_CYC(SC), .REWRITE_CYC(LC),
    .TOL_SGN(TSG), .TOL_FRC(TFR)) u_wiper_nv_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wiper(wiper), .busy(busy), .cmd_err(cmd_err), .nv_read_on(nv_read_on));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input logic rd, input logic [4:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_rd = rd; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_rd = 1'b0;
  endtask

  task automatic rd_take(input string req, input int exp);
    chk({req, " rd_valid"}, int'(rd_valid), 1);
    chk({req, " rd_data"}, int'(rd_data), exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    chk({req, " rd_valid falls"}, int'(rd_valid), 0);
  endtask

  task automatic nv_read(input string req, input logic [4:0] a, input int exp);
    cmd(3'b001, 1'b1, a, 8'h00);
    chk({req, " read err"}, int'(cmd_err), 0);
    rd_take(req, exp);
  endtask

  // Issue a timed job and check busy edges exactly
  task automatic timed(input string req, input logic [2:0] op, input logic [4:0] a,
                       input logic [7:0] d, input int len);
    cmd(op, 1'b0, a, d);
    chk({req, " err"}, int'(cmd_err), 0);
    chk({req, " busy start"}, int'(busy), 1);
    cyc(len - 1);
    chk({req, " busy last"}, int'(busy), 1);
    cyc(1);
    chk({req, " busy done"}, int'(busy), 0);
  endtask

  task automatic boot_check(input string req, input int exp_w);
    cyc(RC - 1);
    chk({req, " preset"}, int'(wiper), 32);
    chk({req, " busy"}, int'(busy), 1);
    cyc(1);
    chk({req, " recalled"}, int'(wiper), exp_w);
    cyc(LC - RC - 1);
    chk({req, " lockout last"}, int'(busy), 1);
    cyc(1);
    chk({req, " lockout over"}, int'(busy), 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_nv[i] = 6'h20;
    cyc(3);
    // R1 reset state
    chk("R1 wiper", int'(wiper), 32);
    chk("R1 busy", int'(busy), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 cmd_err", int'(cmd_err), 0);
    chk("R1 nv_read_on", int'(nv_read_on), 0);
    rst_n = 1'b1; por_n = 1'b1;

    // R2 boot recall of a blank bank, R3 drop during lockout
    cyc(RC - 1);
    chk("R2 preset", int'(wiper), 32);
    cyc(1);
    chk("R2 blank recall", int'(wiper), 32);
    cmd(3'b000, 1'b0, 5'd0, 8'h11);
    chk("R3 drop err", int'(cmd_err), 1);
    chk("R3 drop no effect", int'(wiper), 32);
    cyc(LC - RC - 2);
    chk("R3 busy last", int'(busy), 1);
    cyc(1);
    chk("R3 busy over", int'(busy), 0);
    chk("R3 err one pulse", int'(cmd_err), 0);
    for (int i = 0; i < 4; i++) nv_read("R2 blank word", 5'(i), 32);

    // R4 sweep all wiper codes with junk upper bits
    for (int v = 0; v < 64; v++) begin
      cmd(3'b000, 1'b0, 5'(v), {2'(v ^ 2), 6'(v)});
      chk("R4 wiper write", int'(wiper), v);
      cmd(3'b000, 1'b1, 5'd0, 8'hFF);
      rd_take("R4 wiper read", v);
    end

    // R5 every word written with timing, upper data bits ignored
    for (int i = 0; i < 4; i++) begin
      exp_nv[i] = 6'((i * 13 + 5) & 63);
      timed("R5 nv write", 3'b001, 5'(i), {2'b11, exp_nv[i]}, SC);
    end
    for (int i = 0; i < 4; i++) nv_read("R5 nv readback", 5'(i), int'(exp_nv[i]));
    cmd(3'b000, 1'b0, 5'd0, 8'h2A);
    timed("R5 save", 3'b110, 5'd0, 8'h00, SC);
    exp_nv[0] = 6'h2A;
    nv_read("R5 save readback", 5'd0, 'h2A);
    chk("R5 save keeps wiper", int'(wiper), 'h2A);

    // R6 recall by command
    cmd(3'b000, 1'b0, 5'd0, 8'h05);
    cmd(3'b101, 1'b0, 5'd0, 8'h00);
    chk("R6 read state on", int'(nv_read_on), 1);
    chk("R6 busy", int'(busy), 1);
    cyc(RC - 1);
    chk("R6 wiper before", int'(wiper), 5);
    chk("R6 busy last", int'(busy), 1);
    cyc(1);
    chk("R6 wiper recalled", int'(wiper), 'h2A);
    chk("R6 busy done", int'(busy), 0);
    cyc(4);
    chk("R6 read state held", int'(nv_read_on), 1);
    cmd(3'b100, 1'b0, 5'd0, 8'h00);
    chk("R6 NOP clears", int'(nv_read_on), 0);

    // R7 write protection
    cmd(3'b010, 1'b0, 5'd0, 8'h01);
    cmd(3'b001, 1'b0, 5'd1, 8'h3F);
    chk("R7 nv write refused", int'(cmd_err), 1);
    chk("R7 no busy", int'(busy), 0);
    cmd(3'b110, 1'b0, 5'd0, 8'h00);
    chk("R7 save refused", int'(cmd_err), 1);
    nv_read("R7 word1 kept", 5'd1, int'(exp_nv[1]));
    nv_read("R7 word0 kept", 5'd0, int'(exp_nv[0]));
    cmd(3'b000, 1'b0, 5'd0, 8'h3C);
    chk("R7 wiper still writable", int'(wiper), 'h3C);
    cmd(3'b010, 1'b0, 5'd0, 8'hFE);
    exp_nv[1] = 6'h3F;
    timed("R7 unprotected write", 3'b001, 5'd1, 8'h3F, SC);
    nv_read("R7 write landed", 5'd1, 'h3F);

    // R8 tolerance bytes and unmapped locations
    nv_read("R8 sign byte", 5'b11110, int'(TSG));
    nv_read("R8 fraction byte", 5'b11111, int'(TFR));
    cmd(3'b001, 1'b0, 5'b11110, 8'h00);
    chk("R8 tolerance write refused", int'(cmd_err), 1);
    chk("R8 no busy", int'(busy), 0);
    nv_read("R8 sign unchanged", 5'b11110, int'(TSG));
    cmd(3'b001, 1'b0, 5'd7, 8'h15);
    chk("R8 unmapped write refused", int'(cmd_err), 1);
    nv_read("R8 unmapped reads 0", 5'd7, 0);

    // R9 back-pressure
    cmd(3'b000, 1'b1, 5'd0, 8'h00);
    for (int k = 0; k < 3; k++) begin
      chk("R9 held valid", int'(rd_valid), 1);
      chk("R9 held data", int'(rd_data), 'h3C);
      cyc(1);
    end
    cmd(3'b001, 1'b1, 5'b11111, 8'h00);
    chk("R9 second read refused", int'(cmd_err), 1);
    rd_take("R9 original result", 'h3C);

    // R10 undefined opcodes
    cmd(3'b011, 1'b0, 5'd0, 8'h01);
    chk("R10 op011 err", int'(cmd_err), 1);
    cmd(3'b111, 1'b0, 5'd0, 8'h01);
    chk("R10 op111 err", int'(cmd_err), 1);
    chk("R10 wiper kept", int'(wiper), 'h3C);
    chk("R10 no busy", int'(busy), 0);

    // R11 power cycle keeps words
    exp_nv[0] = 6'h1B;
    timed("R11 prepare word0", 3'b001, 5'd0, 8'h1B, SC);
    cmd(3'b000, 1'b0, 5'd0, 8'h30);
    rst_n = 1'b0;
    cyc(2);
    chk("R1 wiper in power cycle", int'(wiper), 32);
    chk("R1 busy in power cycle", int'(busy), 1);
    rst_n = 1'b1;
    boot_check("R11 power cycle", 'h1B);
    for (int i = 0; i < 4; i++) nv_read("R11 word kept", 5'(i), int'(exp_nv[i]));

    // R2 first-power reset blanks the bank
    por_n = 1'b0;
    cyc(2);
    por_n = 1'b1;
    boot_check("R2 blank boot", 32);
    for (int i = 0; i < 4; i++) nv_read("R2 blanked word", 5'(i), 32);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule